// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Sequencer

This block runs complete command transactions to a three-wire serial EEPROM in hardware, in place of a processor toggling pins in software. The host presents a command word together with a count of bits to shift out, a count of bits to shift in, and a flag that asks for a completion poll. It then pulses `start`. The sequencer drives chip select, serial clock and transmit data itself, and samples the receive line. When the transaction has ended it returns the captured read word, or the poll result.

Commands follow the usual three-wire EEPROM layout. Bit 9 is the start bit. Bits 8:7 hold the opcode: 10 read, 01 write, 11 erase, and 00 for the extended group. In the extended group, bits 6:5 select the operation: 11 write-enable, 00 write-disable, 01 write-all, 10 erase-all. The address sits below these fields. The sequencer does not interpret any of these fields. It shifts the low `n_write` bits of `cmd` and leaves framing to the host.

Every pin phase lasts at least one microsecond. The length of a microsecond is set by a parameter that gives the number of system clock cycles per microsecond. Program and erase commands can be followed by a poll. The poll briefly drops chip select, then watches the device's ready line a bounded number of times.

Top module: `uw_seq`

## Requirements
- R1: While reset is held low, and afterwards until the first start, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done`, `timeout` and `rdata` are all 0.
- R2: A `start` pulse is accepted only while `busy` is 0. A `start` that arrives while `busy` is 1 is ignored: no extra transaction runs, and there is no extra `done`.
- R3: The sequencer shifts out the low `n_write` bits of `cmd`, most significant bit first. Each bit on `ee_di` is captured by the device on a rising edge of `ee_sk`. Values of `n_write` above 16 act as 16, and 0 sends no bits.
- R4: `ee_di` holds the same value for at least CYC_PER_US cycles before every rising edge of `ee_sk`.
- R5: Each `ee_sk` pulse is high for at least CYC_PER_US cycles. Before each rising edge, `ee_sk` is low with `ee_cs` high for at least CYC_PER_US cycles.
- R6: Chip select is active high. `ee_sk` is only high while `ee_cs` is high. Every rising edge of `ee_cs` follows at least CYC_PER_US cycles of `ee_cs` low.
- R7: For a read (`n_read` > 0, `poll_mode` = 0), the sequencer gives one full clock pulse and then samples `ee_do`, once per bit. The first sampled bit is the most significant. The result is right-justified in `rdata`, with upper bits 0, and `n_read` above 16 acts as 16.
- R8: In poll mode, after the command bits the sequencer holds `ee_cs` low for one microsecond and then raises it again. It samples `ee_do` at the end of each of up to 10 one-microsecond intervals. A 1 ends the poll with `timeout` = 0. Ten zeros end it with `timeout` = 1.
- R9: When `poll_mode` is 1, `n_read` is ignored. No read pulses are produced, and `rdata` is 0.
- R10: `done` is a single-cycle pulse, and `busy` is 0 while it is high. `rdata` and `timeout` change only in the cycle in which `done` is high, and they hold until the next completion.
- R11: At every `done`, `ee_cs` and `ee_sk` are both already 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that begins a transaction when idle |
| cmd | input | 16 | Command word; the low `n_write` bits are sent |
| n_write | input | 5 | Number of command bits to send |
| n_read | input | 5 | Number of bits to receive |
| poll_mode | input | 1 | Poll for completion instead of reading |
| ee_do | input | 1 | Serial data from the EEPROM |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Received bits, right-justified |
| timeout | output | 1 | Poll ended without seeing ready |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |

## Verification
The timing assertions count cycles on the pins themselves. They assume that `ee_do` comes from a device that changes it well away from the sampling points. They also assume that `start` is not raised in the same cycle as reset release. The stimulus respects both assumptions. Its device model changes `ee_do` only on the falling clock, and only after `ee_sk` rises or after the poll reassertion. The poll ready delays are placed well inside or well outside the ten-sample window, apart from the two that straddle its edge.

// File: rtl/uw_pkg.sv
`timescale 1ns/1ps
// Package: shared state type and pin-decode helpers for the sequencer.
// Assumes: nothing beyond the enum ordering being irrelevant to behaviour.
package uw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,   // waiting for start
        ST_CSS,    // chip select setup before first clock
        ST_WSET,   // data bit set up, clock low
        ST_WHI,    // clock high for a written bit
        ST_WLO,    // clock low after a written bit
        ST_PDROP,  // chip select dropped before polling
        ST_PWAIT,  // chip select high, waiting to sample ready
        ST_RHI,    // clock high for a read bit
        ST_RLO,    // clock low, sample at its end
        ST_END     // chip select inactive hold
    } uw_state_e;

    // Chip select level implied by a state.
    function automatic logic cs_of(uw_state_e s);
        return s inside {ST_CSS, ST_WSET, ST_WHI, ST_WLO, ST_PWAIT, ST_RHI, ST_RLO};
    endfunction

    // Serial clock level implied by a state.
    function automatic logic sk_of(uw_state_e s);
        return s inside {ST_WHI, ST_RHI};
    endfunction

endpackage

// File: rtl/uw_timer.sv
`timescale 1ns/1ps
// Module: uw_timer
// Phase timer. A kick loads a full microsecond. `expired` is high in the
// last cycle of the phase, so every phase lasts exactly CYC_PER_US cycles.
// Assumes: CYC_PER_US >= 1 and the controller kicks on every phase entry.
module uw_timer #(
    parameter int CYC_PER_US = 200,
    parameter int TMR_W      = $clog2(CYC_PER_US + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic expired
);

    logic [TMR_W-1:0] cnt_q;

    // Down-counter: reload on kick, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (kick)
            cnt_q <= TMR_W'(CYC_PER_US - 1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/uw_shift.sv
`timescale 1ns/1ps
// Module: uw_shift
// Datapath: a left-justified transmit shifter, a receive assembler, and
// the result register presented on rdata.
// Assumes: nbits <= DATA_W (the top clamps it); rx shifts never exceed DATA_W.
module uw_shift #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] cmd,
    input  logic [CNT_W-1:0]  nbits,
    input  logic              tx_adv,
    input  logic              rx_shift,
    input  logic              rx_bit,
    input  logic              capture,
    output logic              tx_bit,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] tx_sr_q;
    logic [DATA_W-1:0] rx_sr_q;

    // Transmit shifter: align the send field to the MSB on load, shift per bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_sr_q <= '0;
        else if (load)
            tx_sr_q <= cmd << (DATA_W - int'(nbits));
        else if (tx_adv)
            tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b0};
    end

    // Receive assembler: clear on load, shift sampled bits in at the LSB.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_sr_q <= '0;
        else if (load)
            rx_sr_q <= '0;
        else if (rx_shift)
            rx_sr_q <= {rx_sr_q[DATA_W-2:0], rx_bit};
    end

    // Result register: updated only when the transaction completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (capture)
            rdata <= rx_sr_q;
    end

    assign tx_bit = tx_sr_q[DATA_W-1];

endmodule

// File: rtl/uw_ctrl.sv
`timescale 1ns/1ps
// Module: uw_ctrl
// Transaction state machine. It walks chip select setup, the write bits,
// then either the completion poll or the read bits, then the chip select
// hold. Pin levels are registered from the next state, so the pins do not glitch.
// Assumes: nw/nr already clamped; the timer is kicked whenever the state changes.
module uw_ctrl
    import uw_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int POLL_TRIES = 10,
    parameter int CNT_W      = $clog2(DATA_W + 1),
    parameter int TRY_W      = $clog2(POLL_TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] nw,
    input  logic [CNT_W-1:0] nr,
    input  logic             poll_mode,
    input  logic             expired,
    input  logic             rx_bit,
    input  logic             tx_bit,
    output logic             kick,
    output logic             load,
    output logic             tx_adv,
    output logic             rx_shift,
    output logic             fin,
    output logic             busy,
    output logic             done,
    output logic             timeout,
    output logic             ee_cs,
    output logic             ee_sk,
    output logic             ee_di
);

    uw_state_e        state_q, state_d, after_wr;
    logic [CNT_W-1:0] bits_q, bits_d;
    logic [CNT_W-1:0] nr_q;
    logic [TRY_W-1:0] tries_q, tries_d;
    logic             poll_q;
    logic             fail_q, fail_d;
    logic             restart;

    // Next-state and strobe decode for one transaction.
    always_comb begin
        state_d  = state_q;
        bits_d   = bits_q;
        tries_d  = tries_q;
        fail_d   = fail_q;
        load     = 1'b0;
        tx_adv   = 1'b0;
        rx_shift = 1'b0;
        restart  = 1'b0;
        fin      = 1'b0;
        after_wr = poll_q ? ST_PDROP : ((nr_q != '0) ? ST_RHI : ST_END);
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    fail_d  = 1'b0;
                    bits_d  = nw;
                    state_d = ST_CSS;
                end
            end
            ST_CSS: begin
                if (expired) begin
                    if (bits_q != '0) begin
                        tx_adv  = 1'b1;
                        state_d = ST_WSET;
                    end else begin
                        bits_d  = nr_q;
                        state_d = after_wr;
                    end
                end
            end
            ST_WSET: if (expired) state_d = ST_WHI;
            ST_WHI:  if (expired) state_d = ST_WLO;
            ST_WLO: begin
                if (expired) begin
                    if (bits_q == CNT_W'(1)) begin
                        bits_d  = nr_q;
                        state_d = after_wr;
                    end else begin
                        bits_d  = bits_q - 1'b1;
                        tx_adv  = 1'b1;
                        state_d = ST_WSET;
                    end
                end
            end
            ST_PDROP: begin
                if (expired) begin
                    tries_d = '0;
                    state_d = ST_PWAIT;
                end
            end
            ST_PWAIT: begin
                if (expired) begin
                    if (rx_bit) begin
                        state_d = ST_END;
                    end else if (tries_q == TRY_W'(POLL_TRIES - 1)) begin
                        fail_d  = 1'b1;
                        state_d = ST_END;
                    end else begin
                        tries_d = tries_q + 1'b1;
                        restart = 1'b1;
                    end
                end
            end
            ST_RHI: if (expired) state_d = ST_RLO;
            ST_RLO: begin
                if (expired) begin
                    rx_shift = 1'b1;
                    if (bits_q == CNT_W'(1)) begin
                        state_d = ST_END;
                    end else begin
                        bits_d  = bits_q - 1'b1;
                        state_d = ST_RHI;
                    end
                end
            end
            ST_END: begin
                if (expired) begin
                    fin     = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign kick = (state_d != state_q) || restart;
    assign busy = (state_q != ST_IDLE);

    // State, counters and the per-transaction mode latched at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bits_q  <= '0;
            tries_q <= '0;
            fail_q  <= 1'b0;
            poll_q  <= 1'b0;
            nr_q    <= '0;
        end else begin
            state_q <= state_d;
            bits_q  <= bits_d;
            tries_q <= tries_d;
            fail_q  <= fail_d;
            if (load) begin
                poll_q <= poll_mode;
                nr_q   <= nr;
            end
        end
    end

    // Registered pin levels, completion pulse and poll result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ee_cs   <= 1'b0;
            ee_sk   <= 1'b0;
            ee_di   <= 1'b0;
            done    <= 1'b0;
            timeout <= 1'b0;
        end else begin
            ee_cs <= cs_of(state_d);
            ee_sk <= sk_of(state_d);
            done  <= fin;
            if (tx_adv)
                ee_di <= tx_bit;
            else if (state_d == ST_END)
                ee_di <= 1'b0;
            if (fin)
                timeout <= fail_q;
        end
    end

endmodule

// File: rtl/uw_seq.sv
`timescale 1ns/1ps
// Module: uw_seq (top)
// Three-wire serial EEPROM command sequencer. It clamps the bit counts and
// wires the phase timer, datapath and controller together.
// Assumes: ee_do is quiet around the sampling points (no synchronizer here).
module uw_seq #(
    parameter int   DATA_W     = 16,
    parameter int   CYC_PER_US = 200,
    parameter int   POLL_TRIES = 10,
    localparam int  CNT_W      = $clog2(DATA_W + 1),
    localparam int  TMR_W      = $clog2(CYC_PER_US + 1),
    localparam int  TRY_W      = $clog2(POLL_TRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] cmd,
    input  logic [CNT_W-1:0]  n_write,
    input  logic [CNT_W-1:0]  n_read,
    input  logic              poll_mode,
    input  logic              ee_do,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              timeout,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di
);

    logic [CNT_W-1:0] nw_c, nr_c;
    logic kick, expired, load, tx_adv, rx_shift, fin, tx_bit;

    // Clamp the requested counts to the word width.
    always_comb begin
        nw_c = (n_write > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : n_write;
        nr_c = (n_read  > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : n_read;
    end

    uw_timer #(
        .CYC_PER_US (CYC_PER_US),
        .TMR_W      (TMR_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .kick    (kick),
        .expired (expired)
    );

    uw_shift #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .cmd      (cmd),
        .nbits    (nw_c),
        .tx_adv   (tx_adv),
        .rx_shift (rx_shift),
        .rx_bit   (ee_do),
        .capture  (fin),
        .tx_bit   (tx_bit),
        .rdata    (rdata)
    );

    uw_ctrl #(
        .DATA_W     (DATA_W),
        .POLL_TRIES (POLL_TRIES),
        .CNT_W      (CNT_W),
        .TRY_W      (TRY_W)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .nw        (nw_c),
        .nr        (nr_c),
        .poll_mode (poll_mode),
        .expired   (expired),
        .rx_bit    (ee_do),
        .tx_bit    (tx_bit),
        .kick      (kick),
        .load      (load),
        .tx_adv    (tx_adv),
        .rx_shift  (rx_shift),
        .fin       (fin),
        .busy      (busy),
        .done      (done),
        .timeout   (timeout),
        .ee_cs     (ee_cs),
        .ee_sk     (ee_sk),
        .ee_di     (ee_di)
    );

endmodule

// File: rtl/uw_seq_chk.sv
`timescale 1ns/1ps
// Module: uw_seq_chk
// Pin-level protocol checker, bound into uw_seq. Minimum widths are measured
// with saturating counters, so no long $past windows are needed.
// Assumes: counters start saturated at reset, since reset counts as idle time.
module uw_seq_chk #(
    parameter int DATA_W     = 16,
    parameter int CYC_PER_US = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] rdata,
    input logic              timeout,
    input logic              ee_cs,
    input logic              ee_sk,
    input logic              ee_di
);

    int   hi_n, lo_n, cs_lo_n, di_n;
    logic di_q;

    // Width counters: clock high, clock low under select, select low, data stable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_n    <= 0;
            lo_n    <= 0;
            cs_lo_n <= CYC_PER_US;
            di_n    <= CYC_PER_US;
            di_q    <= 1'b0;
        end else begin
            hi_n    <= ee_sk ? ((hi_n < CYC_PER_US) ? hi_n + 1 : hi_n) : 0;
            lo_n    <= (ee_cs && !ee_sk) ? ((lo_n < CYC_PER_US) ? lo_n + 1 : lo_n) : 0;
            cs_lo_n <= !ee_cs ? ((cs_lo_n < CYC_PER_US) ? cs_lo_n + 1 : cs_lo_n) : 0;
            di_q    <= ee_di;
            di_n    <= (ee_di == di_q) ? ((di_n < CYC_PER_US) ? di_n + 1 : di_n) : 0;
        end
    end

    // R4: data stable for a full microsecond ahead of each rising clock edge
    a_r4_di_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sk) |-> di_n >= CYC_PER_US - 1);

    a_r5_sk_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_sk) |-> hi_n >= CYC_PER_US);

    a_r5_sk_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sk) |-> lo_n >= CYC_PER_US);

    a_r6_sk_within_cs: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs);

    a_r6_cs_off_time: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> cs_lo_n >= CYC_PER_US);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> done);

    a_r10_timeout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(timeout) |-> done);

    a_r11_idle_pins_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ee_cs && !ee_sk));

endmodule

bind uw_seq uw_seq_chk #(
    .DATA_W     (DATA_W),
    .CYC_PER_US (CYC_PER_US)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .rdata   (rdata),
    .timeout (timeout),
    .ee_cs   (ee_cs),
    .ee_sk   (ee_sk),
    .ee_di   (ee_di)
);

// File: tb/sim_uw_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected results, the monitor pops at done.
module sim_uw_seq;

    localparam int US = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cmd = '0;
    logic [4:0]  n_write = '0;
    logic [4:0]  n_read = '0;
    logic        poll_mode = 1'b0;
    logic        ee_do = 1'b0;
    logic        busy, done, timeout, ee_cs, ee_sk, ee_di;
    logic [15:0] rdata;

    always #2.5 clk = ~clk;

    uw_seq #(.CYC_PER_US(US)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
        .n_write(n_write), .n_read(n_read), .poll_mode(poll_mode),
        .ee_do(ee_do), .busy(busy), .done(done), .rdata(rdata),
        .timeout(timeout), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
    );

    typedef struct {
        int          nbits;
        logic [15:0] wbits;
        logic [15:0] rd;
        logic        tmo;
        int          pulses;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0, n_bad = 0, dones = 0;
    bit   finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Device model state
    int          m_nw = 0, m_delay = 0, edges = 0, rises = 0, pcnt = 0;
    bit          m_poll = 0, polling = 0;
    logic [15:0] m_resp = '0;
    logic        cs_m = 0, sk_m = 0;

    // Device model: reacts to select and clock edges on the falling clock.
    always @(negedge clk) begin
        if (ee_cs && !cs_m) begin
            rises++;
            if (rises == 1) begin
                edges = 0;
                ee_do = 1'b0;
            end else if (m_poll) begin
                polling = 1;
                pcnt = 0;
            end
        end
        if (!ee_cs) polling = 0;
        if (polling) begin
            if (pcnt >= m_delay) ee_do = 1'b1;
            pcnt++;
        end
        if (ee_cs && ee_sk && !sk_m) begin
            edges++;
            if (edges > m_nw && !m_poll) ee_do = m_resp[15 - (edges - m_nw - 1)];
        end
        cs_m = ee_cs;
        sk_m = ee_sk;
    end

    // Monitor: captures sent bits, measures pin widths, scores at done.
    logic [63:0] cap = '0;
    int pulses = 0, hi_len = 0, lo_len = 0, cs_lo_len = 1000, di_len = 1000;
    int min_hi = 1000, min_lo = 1000, min_cs = 1000, min_di = 1000;
    logic mp_sk = 0, mp_cs = 0, mp_di = 0, mp_done = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ee_sk && !mp_sk) begin
                cap = {cap[62:0], ee_di};
                pulses++;
                if (lo_len < min_lo) min_lo = lo_len;
                if (di_len < min_di) min_di = di_len;
            end
            if (!ee_sk && mp_sk && hi_len < min_hi) min_hi = hi_len;
            if (ee_cs && !mp_cs && cs_lo_len < min_cs) min_cs = cs_lo_len;
            if (mp_done && done) chk(0, "R10", "done longer than one cycle", 1, 0);
            if (done) begin
                chk(!busy, "R10", "busy during done", busy, 0);
                chk(!ee_cs && !ee_sk, "R11", "cs/sk at done", {ee_cs, ee_sk}, 0);
                if (q.size() == 0) begin
                    chk(0, "R2", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    logic [63:0] wb;
                    e = q.pop_front();
                    wb = (pulses >= e.nbits) ? (cap >> (pulses - e.nbits)) : cap;
                    wb = wb & ((64'd1 << e.nbits) - 1);
                    chk(pulses == e.pulses, "R7/R9", "clock pulse count", pulses, e.pulses);
                    chk(wb == {48'd0, e.wbits}, "R3", "sent bits", wb, e.wbits);
                    chk(rdata == e.rd, "R7", "rdata", rdata, e.rd);
                    chk(timeout == e.tmo, "R8", "timeout", timeout, e.tmo);
                end
                cap = '0;
                pulses = 0;
                dones++;
            end
        end
        hi_len    = ee_sk ? hi_len + 1 : 0;
        lo_len    = (ee_cs && !ee_sk) ? lo_len + 1 : 0;
        cs_lo_len = ee_cs ? 0 : cs_lo_len + 1;
        di_len    = (ee_di == mp_di) ? di_len + 1 : 1;
        mp_sk = ee_sk; mp_cs = ee_cs; mp_di = ee_di; mp_done = done;
    end

    logic [15:0] last_rd = '0;
    logic        last_tmo = 0;

    // Driver: computes the expected item, pushes it, runs the transaction.
    task automatic run(input logic [15:0] c, input int nw, input int nr,
                       input bit poll, input logic [15:0] resp, input int delay,
                       input bit poke_busy);
        exp_t e;
        int   nb, nrc, d0;
        nb  = (nw > 16) ? 16 : nw;
        nrc = (nr > 16) ? 16 : nr;
        e.nbits  = nb;
        e.wbits  = (nb == 0) ? 16'd0 : c & 16'((32'd1 << nb) - 1);
        e.rd     = (poll || nrc == 0) ? 16'd0 : 16'(resp >> (16 - nrc));
        e.tmo    = poll && (delay > 10 * US - 1);
        e.pulses = nb + (poll ? 0 : nrc);
        @(negedge clk);
        chk(rdata == last_rd && timeout == last_tmo, "R10", "result held",
            {rdata, timeout}, {last_rd, last_tmo});
        m_nw = nb; m_poll = poll; m_resp = resp; m_delay = delay; rises = 0;
        q.push_back(e);
        cmd = c; n_write = 5'(nw); n_read = 5'(nr); poll_mode = poll;
        start = 1'b1;
        d0 = dones;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            repeat (30) @(negedge clk);
            chk(busy, "R2", "busy mid-transaction", busy, 1);
            cmd = 16'hFFFF; n_write = 5'd16; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (dones == d0) @(negedge clk);
        last_rd = e.rd;
        last_tmo = e.tmo;
        if (poke_busy) begin
            repeat (40) @(negedge clk);
            chk(dones == d0 + 1 && !busy, "R2", "extra transaction", dones - d0, 1);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk({ee_cs, ee_sk, ee_di, busy, done, timeout} == 6'd0 && rdata == 16'd0,
            "R1", "outputs in reset", {ee_cs, ee_sk, ee_di, busy, done, timeout}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({ee_cs, ee_sk, ee_di, busy, done, timeout} == 6'd0 && rdata == 16'd0,
            "R1", "outputs idle after reset", {ee_cs, ee_sk, ee_di, busy, done, timeout}, 0);
        run(16'h0260, 10, 0, 0, 16'h0000, 0, 0);     // R3 write-enable
        run(16'h032A, 10, 16, 0, 16'hBEEF, 0, 0);    // R7 full read
        run(16'h0311, 10, 8, 0, 16'hA55A, 0, 0);     // R7 short read
        run(16'h0000, 0, 1, 0, 16'h8000, 0, 0);      // R3 zero write, R7 one bit
        run(16'hC3A5, 20, 0, 0, 16'h0000, 0, 0);     // R3 clamp to 16
        run(16'h0001, 1, 0, 0, 16'h0000, 0, 0);      // R3 single bit
        run(16'h02B3, 10, 0, 1, 16'h0000, 0, 0);     // R8 ready at once
        run(16'h02B4, 10, 0, 1, 16'h0000, 12, 0);    // R8 ready early
        run(16'h03C5, 10, 0, 1, 16'h0000, 45, 0);    // R8 ready just inside window
        run(16'h03C6, 10, 0, 1, 16'h0000, 56, 0);    // R8 just outside -> timeout
        run(16'h0240, 10, 0, 1, 16'h0000, 1000, 0);  // R8 never ready
        run(16'h02B7, 10, 8, 1, 16'hFFFF, 3, 0);     // R9 poll ignores n_read
        run(16'h0305, 10, 16, 0, 16'h1234, 0, 1);    // R2 start while busy
        run(16'h0306, 10, 20, 0, 16'h8421, 0, 0);    // R7 read clamp to 16
        chk(min_di >= US, "R4", "di setup cycles", min_di, US);
        chk(min_hi >= US, "R5", "sk high cycles", min_hi, US);
        chk(min_lo >= US, "R5", "sk low cycles", min_lo, US);
        chk(min_cs >= US, "R6", "cs off cycles", min_cs, US);
        chk(q.size() == 0, "R2", "pending expectations", q.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule